// File: doc/BRIEF.md
# Warp Load Coalescer

This block sits between a 32-lane execution unit and a line-based memory port. In one cycle it takes a warp-wide load: each lane brings a byte address and an active flag. The block groups the active lanes by the 128-byte-aligned line their address falls in. It then sends exactly one line fetch for each distinct line, one fetch at a time, on a valid/ready request channel.

Each returned line is cut into 32-bit words. Every lane that maps to that line takes the word picked by its own address. Once the last line has come back, the block shows the gathered 32-lane result with a one-cycle done pulse. It also reports how many fetches that warp needed. The fetch count depends only on the addresses:

- a unit-stride warp on an aligned line needs one fetch;
- a fully scattered warp needs up to 32 fetches.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready is 1, mem_valid is 0, done is 0, txn_count is 0 and every res_data word is 0.
- R2: Each distinct 128-byte line (line address = byte address bits [31:7]) touched by at least one active lane is fetched exactly once per warp. 32 active lanes reading consecutive 4-byte words from one aligned line produce exactly one fetch.
- R3: The data-dependent fetch counts are as follows:
  - a 2-word (8-byte) stride from an aligned base gives 2 fetches;
  - a 16-byte stride from an aligned base gives 4 fetches;
  - 32 lanes on 32 different lines give 32 fetches;
  - a unit-stride warp starting half-way into a line gives 2 fetches.
- R4: Fetches go out in ascending order of the lowest-numbered active lane that maps to each line.
- R5: Inactive lanes cause no fetch, and their res_data word (bits [32*i+31:32*i] for lane i) is 0. A warp with no active lane issues no fetch and still raises done, with txn_count 0.
- R6: An active lane i receives word number addr[6:2] of its line's returned data. Word w of the line is rsp_data bits [32*w+31:32*w]. Lanes sharing a word all receive it.
- R7: mem_line_addr holds bits [31:7] of the line being fetched. While mem_valid is 1 and mem_ready is 0, both stay unchanged in the next cycle.
- R8: A warp is accepted only when req_ready and req_valid are both 1. req_ready stays 0 from the cycle after acceptance until done has pulsed, and requests offered in that time are ignored.
- R9: At most one fetch is outstanding. After a fetch handshake mem_valid is 0 until the response (rsp_valid) has been taken, whatever the response latency.
- R10: done is a one-cycle pulse. While done is 1, and until the next warp is accepted, res_data and txn_count hold that warp's result.
- R11: txn_count equals the number of fetch handshakes the last completed warp used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A warp request is offered |
| req_ready | output | 1 | The block can take a warp request |
| req_active | input | 32 | Per-lane active flags |
| req_addr | input | 1024 | Per-lane byte addresses, lane i in bits [32*i+31:32*i] |
| mem_valid | output | 1 | A line fetch is offered |
| mem_ready | input | 1 | The memory takes the line fetch |
| mem_line_addr | output | 25 | Line address (byte address bits [31:7]) of the fetch |
| rsp_valid | input | 1 | Returned line data is present |
| rsp_data | input | 1024 | Returned line, word w in bits [32*w+31:32*w] |
| done | output | 1 | One-cycle pulse: the warp result is complete |
| res_data | output | 1024 | Gathered result, lane i in bits [32*i+31:32*i] |
| txn_count | output | 6 | Fetches used by the last completed warp |

## Verification
The assertions assume a well-behaved memory side. rsp_valid rises only while a fetch is outstanding, and it is held for one cycle per fetch. The assertions also assume that reset is applied before any request is offered.

The stimulus keeps to this. The memory model answers each handshake with exactly one single-cycle response after a random delay of 0 to 2 cycles. Its mem_ready stalls are random, and a warp is offered only while req_ready is up. Requests offered during a busy warp are deliberate: they carry foreign addresses, so that ignoring them can be seen in the results.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } coal_state_t;

endpackage

// File: rtl/coal_rst_sync.sv
module coal_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/coal_leader.sv
module coal_leader #(
  parameter int LANES  = 32,
  parameter int LINE_W = 25
) (
  input  logic [LANES-1:0]        pend,
  input  logic [LANES*LINE_W-1:0] lines,
  output logic [LINE_W-1:0]       lead_line,
  output logic [LANES-1:0]        match
);

  // lowest pending lane selects the line to fetch next
  always_comb begin
    logic found;
    found     = 1'b0;
    lead_line = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pend[i] && !found) begin
        lead_line = lines[i*LINE_W +: LINE_W];
        found     = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_match
    assign match[g] = pend[g] && (lines[g*LINE_W +: LINE_W] == lead_line);
  end

endmodule

// File: rtl/coal_gather.sv
module coal_gather #(
  parameter int LANES  = 32,
  parameter int WORD_W = 32,
  parameter int WPL    = 32,
  localparam int WSEL_W = $clog2(WPL),
  localparam int LDW    = WPL * WORD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    load,
  input  logic [LANES-1:0]        match,
  input  logic [LANES*WSEL_W-1:0] wsel,
  input  logic [LDW-1:0]          line_data,
  output logic [LANES*WORD_W-1:0] res
);

  logic [WORD_W-1:0] words [WPL];

  for (genvar w = 0; w < WPL; w++) begin : g_split
    assign words[w] = line_data[w*WORD_W +: WORD_W];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD_W-1:0] res_q, res_d;
    logic              res_en;
    logic [WSEL_W-1:0] sel;

    assign sel    = wsel[g*WSEL_W +: WSEL_W];
    assign res_en = clr || (load && match[g]);

    always_comb begin
      if (clr) res_d = '0;
      else     res_d = words[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      res_q <= '0;
      else if (res_en) res_q <= res_d;
    end

    assign res[g*WORD_W +: WORD_W] = res_q;
  end

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int WORD_W     = 32,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int SUB_W  = $clog2(WORD_W / 8),
  localparam int WPL    = LINE_BYTES / (WORD_W / 8),
  localparam int WSEL_W = OFF_W - SUB_W,
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int KEEP_W = ADDR_W - SUB_W,
  localparam int LDW    = LINE_BYTES * 8,
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES-1:0]        req_active,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [LINE_W-1:0]       mem_line_addr,
  input  logic                    rsp_valid,
  input  logic [LDW-1:0]          rsp_data,
  output logic                    done,
  output logic [LANES*WORD_W-1:0] res_data,
  output logic [CNT_W-1:0]        txn_count
);

  logic rst_s_n;

  coal_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  coal_state_t st_q, st_d;
  logic [LANES*KEEP_W-1:0] addr_q, addr_d;
  logic [LANES-1:0]        pend_q, pend_d, match, pend_left;
  logic [CNT_W-1:0]        cnt_q, cnt_d, last_q, last_d;
  logic [LANES*LINE_W-1:0] lines;
  logic [LANES*WSEL_W-1:0] wsel;
  logic [LINE_W-1:0]       lead_line;
  logic                    accept, rsp_take, addr_en;

  // per-lane fields: drop byte-in-word bits, split line and word index
  for (genvar g = 0; g < LANES; g++) begin : g_fields
    assign addr_d[g*KEEP_W +: KEEP_W]  = req_addr[g*ADDR_W + SUB_W +: KEEP_W];
    assign lines[g*LINE_W +: LINE_W]   = addr_q[g*KEEP_W + WSEL_W +: LINE_W];
    assign wsel[g*WSEL_W +: WSEL_W]    = addr_q[g*KEEP_W +: WSEL_W];
  end

  coal_leader #(
    .LANES  (LANES),
    .LINE_W (LINE_W)
  ) u_lead (
    .pend      (pend_q),
    .lines     (lines),
    .lead_line (lead_line),
    .match     (match)
  );

  assign accept    = (st_q == ST_IDLE) && req_valid;
  assign rsp_take  = (st_q == ST_WAIT) && rsp_valid;
  assign addr_en   = accept;
  assign pend_left = pend_q & ~match;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          pend_d = req_active;
          cnt_d  = '0;
          if (|req_active) begin
            st_d = ST_ISSUE;
          end else begin
            st_d   = ST_DONE;
            last_d = '0;
          end
        end
      end
      ST_ISSUE: begin
        if (mem_ready) begin
          cnt_d = cnt_q + CNT_W'(1);
          st_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          pend_d = pend_left;
          if (pend_left == '0) begin
            st_d   = ST_DONE;
            last_d = cnt_q;
          end else begin
            st_d = ST_ISSUE;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  coal_gather #(
    .LANES  (LANES),
    .WORD_W (WORD_W),
    .WPL    (WPL)
  ) u_gather (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .clr       (accept),
    .load      (rsp_take),
    .match     (match),
    .wsel      (wsel),
    .line_data (rsp_data),
    .res       (res_data)
  );

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_valid     = (st_q == ST_ISSUE);
  assign mem_line_addr = lead_line;
  assign done          = (st_q == ST_DONE);
  assign txn_count     = last_q;

endmodule

// File: rtl/coal_chk.sv
module coal_chk #(
  parameter int LANES  = 32,
  parameter int LINE_W = 25,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LANES-1:0]  req_active,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [LINE_W-1:0] mem_line_addr,
  input logic              done,
  input logic [CNT_W-1:0]  txn_count
);

  logic [CNT_W-1:0] hs_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hs_cnt <= '0;
    else if (req_valid && req_ready)  hs_cnt <= '0;
    else if (mem_valid && mem_ready)  hs_cnt <= hs_cnt + CNT_W'(1);
  end

  // R7
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_line_addr)));

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> !mem_valid);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  empty_warp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_active == '0)) |=> (done && !mem_valid));

  // R11
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (txn_count == hs_cnt));

endmodule

bind warp_coalescer coal_chk #(
  .LANES  (LANES),
  .LINE_W (LINE_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_active    (req_active),
  .mem_valid     (mem_valid),
  .mem_ready     (mem_ready),
  .mem_line_addr (mem_line_addr),
  .done          (done),
  .txn_count     (txn_count)
);

// File: tb/sim_warp_coalescer.sv
module sim_warp_coalescer;

  localparam int L = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, mem_valid, mem_ready, rsp_valid, done;
  logic [L-1:0]  req_active;
  logic [L*32-1:0] req_addr, res_data;
  logic [1023:0] rsp_data;
  logic [24:0]   mem_line_addr;
  logic [5:0]    txn_count;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] a [L];
  logic [L-1:0] act;
  logic [24:0] exp_line [L];
  int exp_n;

  always #10 clk = ~clk;

  warp_coalescer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_addr(req_addr), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_line_addr(mem_line_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .done(done), .res_data(res_data), .txn_count(txn_count)
  );

  function automatic logic [31:0] mem_word(input logic [24:0] ln, input int w);
    return ({7'd0, ln} * 32'h9E37_79B1) ^ {w[7:0], 8'h5A, w[7:0], ln[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] actv, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, actv, expv);
    end
  endtask

  task automatic compute_expect();
    exp_n = 0;
    for (int i = 0; i < L; i++) begin
      if (act[i]) begin
        bit seen = 0;
        for (int k = 0; k < exp_n; k++)
          if (exp_line[k] == a[i][31:7]) seen = 1;
        if (!seen) begin
          exp_line[exp_n] = a[i][31:7];
          exp_n++;
        end
      end
    end
  endtask

  task automatic run_warp(input string tag, input bit noise);
    int k = 0;
    int guard = 0;
    bit order_ok = 1;
    bit busy_ok = 1;
    bit idle_ok = 1;
    logic [24:0] bad_line = '0;
    compute_expect();
    @(negedge clk);
    for (int i = 0; i < L; i++) req_addr[i*32 +: 32] = a[i];
    req_active = act;
    req_valid  = 1'b1;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      guard++;
      if (done || guard > 400) begin
        req_valid = 1'b0;
        break;
      end
      if (req_ready) busy_ok = 0;
      // R8: offer a foreign warp while busy
      req_valid = noise;
      if (noise) begin
        for (int i = 0; i < L; i++) req_addr[i*32 +: 32] = $urandom;
        req_active = '1;
      end
      if (mem_valid) begin
        if ($urandom % 4 == 0) begin
          mem_ready = 1'b0;
          continue;
        end
        mem_ready = 1'b1;
        if (k >= exp_n || mem_line_addr != exp_line[k]) begin
          if (order_ok) bad_line = mem_line_addr;
          order_ok = 0;
        end
        begin
          logic [24:0] ln = mem_line_addr;
          k++;
          @(negedge clk);
          mem_ready = 1'b0;
          req_valid = noise;
          if (mem_valid) idle_ok = 0;
          repeat ($urandom % 3) begin
            @(negedge clk);
            if (mem_valid) idle_ok = 0;
          end
          for (int w = 0; w < 32; w++) rsp_data[w*32 +: 32] = mem_word(ln, w);
          rsp_valid = 1'b1;
        end
      end
    end
    chk(done, "R10", {tag, " done pulse"}, 64'(done), 64'd1);
    chk(order_ok && k == exp_n, "R4", {tag, " fetch order"}, 64'(bad_line),
        64'(exp_n > 0 ? exp_line[0] : 25'd0));
    chk(k == exp_n, "R2", {tag, " fetches seen"}, 64'(k), 64'(exp_n));
    chk(txn_count == 6'(exp_n), "R11", {tag, " txn_count"}, 64'(txn_count), 64'(exp_n));
    chk(busy_ok, "R8", {tag, " req_ready low while busy"}, 64'(busy_ok), 64'd1);
    chk(idle_ok, "R9", {tag, " mem_valid low while waiting"}, 64'(idle_ok), 64'd1);
    begin
      bit res_ok = 1;
      logic [31:0] ra = '0, re = '0;
      for (int i = 0; i < L; i++) begin
        logic [31:0] e = act[i] ? mem_word(a[i][31:7], int'(a[i][6:2])) : 32'd0;
        if (res_data[i*32 +: 32] !== e && res_ok) begin
          res_ok = 0; ra = res_data[i*32 +: 32]; re = e;
        end
      end
      chk(res_ok, "R6", {tag, " gathered words"}, 64'(ra), 64'(re));
      @(negedge clk);
      chk(!done && res_data[31:0] === (act[0] ? mem_word(a[0][31:7], int'(a[0][6:2])) : 32'd0)
          && txn_count == 6'(exp_n), "R10", {tag, " result held after done"},
          64'(txn_count), 64'(exp_n));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; req_valid = 1'b0; req_active = '0; req_addr = '0;
    mem_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !mem_valid && !done && txn_count == 0 && res_data == '0,
        "R1", "reset state", {62'd0, req_ready, done}, 64'd2);

    // R2 unit stride, one aligned line
    for (int i = 0; i < L; i++) a[i] = 32'h0001_0000 + 4 * i;
    act = '1; run_warp("R2 unit", 0);
    chk(txn_count == 1, "R2", "unit stride count", 64'(txn_count), 64'd1);

    // R3 stride two words
    for (int i = 0; i < L; i++) a[i] = 32'h0002_0000 + 8 * i;
    act = '1; run_warp("R3 stride2", 1);
    chk(txn_count == 2, "R3", "stride 2 count", 64'(txn_count), 64'd2);

    // R3 16-byte structure stride
    for (int i = 0; i < L; i++) a[i] = 32'h0003_0000 + 16 * i;
    act = '1; run_warp("R3 aos", 0);
    chk(txn_count == 4, "R3", "16-byte stride count", 64'(txn_count), 64'd4);

    // R3 fully scattered, lines out of lane order
    for (int i = 0; i < L; i++) a[i] = 32'h0010_0000 + 128 * ((i * 7) % 32) + 4 * i;
    act = '1; run_warp("R3 scatter", 1);
    chk(txn_count == 32, "R3", "scattered count", 64'(txn_count), 64'd32);

    // R3 unit stride starting mid-line
    for (int i = 0; i < L; i++) a[i] = 32'h0004_0040 + 4 * i;
    act = '1; run_warp("R3 midline", 0);
    chk(txn_count == 2, "R3", "mid-line count", 64'(txn_count), 64'd2);

    // R5 no active lane
    for (int i = 0; i < L; i++) a[i] = 32'h0005_0000 + 128 * i;
    act = '0; run_warp("R5 empty", 0);
    chk(txn_count == 0 && res_data == '0, "R5", "empty warp", 64'(txn_count), 64'd0);

    // R5 only odd lanes active, even lanes on their own lines
    for (int i = 0; i < L; i++) a[i] = (i % 2) ? 32'h0006_0000 + 4 * i : 32'h0007_0000 + 128 * i;
    act = 32'hAAAA_AAAA; run_warp("R5 odd", 1);
    chk(txn_count == 1, "R5", "inactive lanes fetch nothing", 64'(txn_count), 64'd1);

    // R6 all lanes on one word
    for (int i = 0; i < L; i++) a[i] = 32'h0008_007C;
    act = '1; run_warp("R6 broadcast", 0);

    // R4 lowest lane on a late line
    for (int i = 0; i < L; i++) a[i] = 32'h0009_0000 + 128 * (3 - (i % 4)) + 4 * (i % 32);
    act = '1; run_warp("R4 reverse", 0);

    // random mix over a small line pool
    for (int r = 0; r < 40; r++) begin
      logic [31:0] base = {$urandom % 32'h0100_0000, 7'd0} & 32'hFFFF_FF80;
      for (int i = 0; i < L; i++)
        a[i] = base + 128 * ($urandom % 6) + 4 * ($urandom % 32);
      act = ($urandom % 4 == 0) ? '1 : $urandom;
      run_warp("R2 random", ($urandom % 2) == 1);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule